// File: doc/BRIEF.md
# Coin Accumulating Vending Controller

This block is a clocked controller for a dispenser that sells one item for 15 cents. Each cycle it can take one coin event, marked by a valid strobe. The coin is a nickel, a dime or an unacceptable coin. The block keeps the credit collected so far, which is 0, 5 or 10 cents. For every coin it answers with an action code in the same cycle: wait for more money, dispense, or reject the coin.

Change is never paid out. A payment of 20 cents dispenses one item and keeps 5 cents as credit for the next purchase. An unacceptable coin is refused and the credit stays as it was. The action is computed from the present credit and the coin on the bus, so it is a Mealy output. The credit register takes its new value on the clock edge that ends the coin's cycle.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets the credit to 0 cents.
- R2: When coin_valid is low, action is 00 (hold) and the credit does not change at the next edge.
- R3: With 0 cents of credit, a nickel (code 00) gives hold (00) and leaves 5 cents. A dime (code 01) gives hold and leaves 10 cents.
- R4: With 5 cents of credit, a nickel gives hold and leaves 10 cents. A dime gives dispense (01) and leaves 0 cents.
- R5: With 10 cents of credit, a nickel gives dispense (01) and leaves 0 cents.
- R6: With 10 cents of credit, a dime gives dispense (01) and leaves 5 cents.
- R7: A bad coin (code 10) in any credit state gives reject (10) and leaves the credit unchanged.
- R8: Coin code 11, or a credit register that holds the unused encoding 11, gives reject (10) and sets the credit to 0 cents.
- R9: action follows coin_code and coin_valid within the same cycle, with no register in between. Its value depends on both the present credit and the coin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coin_code | input | 2 | Coin code: 00 nickel, 01 dime, 10 bad coin, 11 illegal |
| coin_valid | input | 1 | High for a cycle that carries one coin |
| action | output | 2 | Action code: 00 hold, 01 dispense, 10 reject |

## Verification
The credit cannot be read at the ports. A wrong credit value therefore shows up only in the action code of a later coin. A dime answers hold only when the credit is 0 cents. After a dime that dispensed, a second dime answers hold only when the first one started from 5 cents. The bench uses this two-coin probe to recover the credit after every scenario. A corrupted credit is caught within two coin cycles of the point where it goes wrong, and a wrong action is caught in the cycle the coin is presented.

// File: rtl/vend_pkg.sv
// Package: vend_pkg
// Holds the code widths and the encodings shared by the vending controller.
// Assumes 2-bit coin, credit and action codes. The credit encoding matters:
// the value is the credit in nickels (0, 1, 2).
package vend_pkg;

    localparam int COIN_W   = 2;
    localparam int CREDIT_W = 2;
    localparam int ACT_W    = 2;

    // Coin codes on the input bus.
    typedef enum logic [COIN_W-1:0] {
        COIN_NICKEL  = 2'b00,
        COIN_DIME    = 2'b01,
        COIN_BAD     = 2'b10,
        COIN_ILLEGAL = 2'b11
    } coin_e;

    // Credit held between coins, counted in nickels.
    typedef enum logic [CREDIT_W-1:0] {
        CRED_0C   = 2'b00,
        CRED_5C   = 2'b01,
        CRED_10C  = 2'b10,
        CRED_VOID = 2'b11
    } credit_e;

    // Action codes on the output bus.
    typedef enum logic [ACT_W-1:0] {
        ACT_HOLD   = 2'b00,
        ACT_VEND   = 2'b01,
        ACT_REJECT = 2'b10,
        ACT_SPARE  = 2'b11
    } act_e;

endpackage

// File: rtl/vend_next_logic.sv
// Module: vend_next_logic
// Combinational transition and action decode of the vending controller.
// Given the present credit and the coin event, it returns the next credit
// and the Mealy action. With no valid coin, it keeps the credit and
// answers hold. An illegal coin or a void credit goes to 0 cents with reject.
// Assumes: at most one coin per cycle.
module vend_next_logic
    import vend_pkg::*;
(
    input  credit_e              cur_credit,
    input  logic [COIN_W-1:0]    coin_code,
    input  logic                 coin_valid,
    output credit_e              nxt_credit,
    output act_e                 act
);

    coin_e coin;

    // Interpret the raw coin bus as a coin type.
    always_comb coin = coin_e'(coin_code);

    // Choose the next credit and the action for this cycle.
    always_comb begin
        nxt_credit = cur_credit;
        act        = ACT_HOLD;
        if (coin_valid) begin
            if (cur_credit == CRED_VOID || coin == COIN_ILLEGAL) begin
                nxt_credit = CRED_0C;
                act        = ACT_REJECT;
            end else if (coin == COIN_BAD) begin
                nxt_credit = cur_credit;
                act        = ACT_REJECT;
            end else begin
                case (cur_credit)
                    CRED_0C: begin
                        nxt_credit = (coin == COIN_DIME) ? CRED_10C : CRED_5C;
                        act        = ACT_HOLD;
                    end
                    CRED_5C: begin
                        nxt_credit = (coin == COIN_DIME) ? CRED_0C : CRED_10C;
                        act        = (coin == COIN_DIME) ? ACT_VEND : ACT_HOLD;
                    end
                    CRED_10C: begin
                        nxt_credit = (coin == COIN_DIME) ? CRED_5C : CRED_0C;
                        act        = ACT_VEND;
                    end
                    default: begin
                        nxt_credit = CRED_0C;
                        act        = ACT_REJECT;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vend_credit_reg.sv
// Module: vend_credit_reg
// Credit register of the vending controller. It loads the next credit on
// cycles with a valid coin and holds otherwise. A synchronous active-low
// reset clears it to 0 cents.
module vend_credit_reg
    import vend_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  credit_e  d,
    output credit_e  q
);

    // Hold the credit between coins; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= CRED_0C;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/coin_vend_ctrl.sv
// Module: coin_vend_ctrl
// Top of the vending controller for a 15-cent item. It accepts one coin per
// valid cycle and keeps 0, 5 or 10 cents of credit. Overpayment is kept as
// credit instead of being paid out as change. The action output is a
// Mealy function of the credit and the coin on the bus.
// Assumes: inputs are synchronous to clk.
module coin_vend_ctrl
    import vend_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COIN_W-1:0]   coin_code,
    input  logic                coin_valid,
    output logic [ACT_W-1:0]    action
);

    credit_e credit_q;
    credit_e credit_d;
    act_e    act_now;

    vend_next_logic u_next (
        .cur_credit (credit_q),
        .coin_code  (coin_code),
        .coin_valid (coin_valid),
        .nxt_credit (credit_d),
        .act        (act_now)
    );

    vend_credit_reg u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (coin_valid),
        .d     (credit_d),
        .q     (credit_q)
    );

    // Drive the action port from the decode.
    always_comb action = act_now;

endmodule

// File: rtl/vend_ctrl_checker.sv
// Module: vend_ctrl_checker
// Property checks for coin_vend_ctrl, bound to the top below. It sees the
// ports and the credit register.
module vend_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] coin_code,
    input logic       coin_valid,
    input logic [1:0] action,
    input logic [1:0] credit
);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_valid |-> action == 2'b00);

    p_idle_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_valid |=> credit == $past(credit));

    p_bad_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b10) |-> action == 2'b10);

    p_bad_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b10 && credit != 2'b11) |=> credit == $past(credit));

    p_illegal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b11) |=> credit == 2'b00);

    p_credit_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        credit != 2'b11);

    p_zero_nickel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b00 && credit == 2'b00) |=> credit == 2'b01);

    p_five_dime_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b01 && credit == 2'b01) |-> action == 2'b01);

    p_vend_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        action == 2'b01 |=> (credit == 2'b00 || credit == 2'b01));

    p_ten_dime_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (coin_valid && coin_code == 2'b01 && credit == 2'b10) |=> credit == 2'b01);

endmodule

bind coin_vend_ctrl vend_ctrl_checker u_vend_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .coin_code  (coin_code),
    .coin_valid (coin_valid),
    .action     (action),
    .credit     (credit_q)
);

// File: tb/coin_vend_ctrl_test.sv
`timescale 1ns/100ps
module coin_vend_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       coin_valid = 1'b0;
    logic [1:0] action;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [1:0] NICKEL = 2'b00, DIME = 2'b01, BAD = 2'b10, ILLEGAL = 2'b11;
    localparam logic [1:0] HOLD = 2'b00, VEND = 2'b01, REJECT = 2'b10;

    coin_vend_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .coin_code  (coin_code),
        .coin_valid (coin_valid),
        .action     (action)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        coin_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Present one coin cycle; return the action seen before the edge.
    task automatic coin(input logic [1:0] code, input logic v, output logic [1:0] a);
        @(negedge clk);
        coin_code = code;
        coin_valid = v;
        #1 a = action;
        @(posedge clk);
        #1 coin_valid = 1'b0;
        coin_code = 2'b00;
    endtask

    // Recover the credit with dimes (alters it).
    task automatic probe(output int cents);
        logic [1:0] a, b;
        coin(DIME, 1'b1, a);
        if (a == HOLD) cents = 0;
        else begin
            coin(DIME, 1'b1, b);
            cents = (b == HOLD) ? 5 : 10;
        end
    endtask

    task automatic set_credit(input int cents);
        logic [1:0] a;
        do_reset();
        for (int i = 0; i < cents / 5; i++) coin(NICKEL, 1'b1, a);
    endtask

    task automatic t_reset();
        int c;
        set_credit(10);
        do_reset();
        probe(c);
        check("R1 credit after reset", c, 0);
    endtask

    task automatic t_idle();
        logic [1:0] a;
        int c;
        set_credit(5);
        for (int i = 0; i < 3; i++) begin
            coin(DIME, 1'b0, a);
            check("R2 action without valid", a, HOLD);
        end
        probe(c);
        check("R2 credit kept while idle", c, 5);
    endtask

    task automatic t_from_zero();
        logic [1:0] a;
        int c;
        set_credit(0);
        coin(NICKEL, 1'b1, a);
        check("R3 nickel at 0c action", a, HOLD);
        probe(c);
        check("R3 nickel at 0c credit", c, 5);
        set_credit(0);
        coin(DIME, 1'b1, a);
        check("R3 dime at 0c action", a, HOLD);
        probe(c);
        check("R3 dime at 0c credit", c, 10);
    endtask

    task automatic t_from_five();
        logic [1:0] a;
        int c;
        set_credit(5);
        coin(NICKEL, 1'b1, a);
        check("R4 nickel at 5c action", a, HOLD);
        probe(c);
        check("R4 nickel at 5c credit", c, 10);
        set_credit(5);
        coin(DIME, 1'b1, a);
        check("R4 dime at 5c action", a, VEND);
        probe(c);
        check("R4 dime at 5c credit", c, 0);
    endtask

    task automatic t_ten_nickel();
        logic [1:0] a;
        int c;
        set_credit(10);
        coin(NICKEL, 1'b1, a);
        check("R5 nickel at 10c action", a, VEND);
        probe(c);
        check("R5 nickel at 10c credit", c, 0);
    endtask

    task automatic t_ten_dime();
        logic [1:0] a;
        int c;
        set_credit(10);
        coin(DIME, 1'b1, a);
        check("R6 dime at 10c action", a, VEND);
        probe(c);
        check("R6 dime at 10c credit", c, 5);
    endtask

    task automatic t_bad();
        logic [1:0] a;
        int c;
        for (int s = 0; s <= 10; s += 5) begin
            set_credit(s);
            coin(BAD, 1'b1, a);
            check("R7 bad coin action", a, REJECT);
            probe(c);
            check("R7 bad coin credit", c, s);
        end
    endtask

    task automatic t_illegal();
        logic [1:0] a;
        int c;
        for (int s = 5; s <= 10; s += 5) begin
            set_credit(s);
            coin(ILLEGAL, 1'b1, a);
            check("R8 illegal coin action", a, REJECT);
            probe(c);
            check("R8 illegal coin credit", c, 0);
        end
    endtask

    // Same-cycle response to bus changes, no edge in between.
    task automatic t_mealy();
        int c;
        set_credit(10);
        @(negedge clk);
        coin_code = NICKEL;
        coin_valid = 1'b1;
        #0.5 check("R9 nickel at 10c same cycle", action, VEND);
        coin_code = BAD;
        #0.5 check("R9 bad coin same cycle", action, REJECT);
        coin_code = DIME;
        #0.3 check("R9 dime at 10c same cycle", action, VEND);
        coin_valid = 1'b0;
        #0.2 check("R9 valid dropped same cycle", action, HOLD);
        @(posedge clk);
        #1 probe(c);
        check("R9 credit after withdrawn coin", c, 10);
    endtask

    // Mixed stream against a model built from R2..R8.
    task automatic t_stream();
        logic [1:0] a;
        int cr, nx, ex;
        do_reset();
        cr = 0;
        for (int i = 0; i < 40; i++) begin
            logic [1:0] code;
            logic v;
            code = 2'((i * 7 + i / 3) % 4);
            if (i % 9 == 8) code = ILLEGAL; else if (code == ILLEGAL) code = NICKEL;
            v = (i % 5 != 4);
            coin(code, v, a);
            if (!v) begin ex = HOLD; nx = cr; end
            else if (code == ILLEGAL) begin ex = REJECT; nx = 0; end
            else if (code == BAD) begin ex = REJECT; nx = cr; end
            else begin
                nx = cr + ((code == DIME) ? 10 : 5);
                if (nx >= 15) begin ex = VEND; nx = nx - 15; end
                else ex = HOLD;
            end
            check("R4 R5 R6 R7 stream action", a, ex);
            cr = nx;
        end
        probe(ex);
        check("R3 stream final credit", ex, cr);
    endtask

    initial begin
        do_reset();
        check("R1 action idle after reset", action, HOLD);
        t_reset();
        t_idle();
        t_from_zero();
        t_from_five();
        t_ten_nickel();
        t_ten_dime();
        t_bad();
        t_illegal();
        t_mealy();
        t_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule